// File: doc/BRIEF.md
# Serial Link Receiver Reset Sequencer

This block owns every receive-side reset of one serial transceiver channel. It watches five status inputs: transmit PLL lock, receive loss-of-signal, receive clock-and-data-recovery (CDR) lock, and the PCS code-violation and disparity-error flags. From these it drives two registered reset outputs, one for the CDR and receive analog front end and one for the receive PCS. Transmit-side resets are driven by other logic and do not pass through this block.

After power-up both resets are held while a fixed settling period runs. The block then waits for the PLL to report lock for a full timed period and releases the CDR reset. It gives the CDR a timed period of steady lock before it releases the PCS reset. It then watches the PCS for an error-free window before it declares the link ready. Every period is a parameter counted in steps of `STEP_CYCLES` clocks. If a lock indication drops while its period is running, that period starts again. If the CDR does not settle within a time limit, the CDR reset is reasserted and the sequence retries from the PLL wait. A fault after the CDR has been released sends the whole sequence back to its first, fully reset, state.

Top module: `rx_reset_sequencer`

## Requirements
- R1: `rst` is synchronous and active high. On the first clock edge at which it is sampled high, the outputs become `state_o`=0, `cdr_rst_o`=1, `pcs_rst_o`=1 and `link_ready_o`=0.
- R2: The state code on `state_o` is 0 for settle, 1 for PLL wait, 2 for CDR wait, 3 for PCS check and 4 for link up. In states 0 and 1 both resets are asserted. State 0 lasts `POWERUP_STEPS` steps and then moves to state 1 without regard to the inputs.
- R3: In state 1 the block moves to state 2 only after the synchronized PLL lock has stayed high, with loss-of-signal low, for `PLL_STEPS` consecutive steps. Any drop in that time restarts the count.
- R4: In state 2 `cdr_rst_o`=0 and `pcs_rst_o`=1. The block moves to state 3 after CDR lock has stayed high for `CDR_STEPS` consecutive steps. Code-violation and disparity flags have no effect in this state.
- R5: If state 2 has lasted `CDR_LIMIT_STEPS` steps without CDR success, the block returns to state 1 with `cdr_rst_o`=1.
- R6: In state 3 both resets are released. The block moves to state 4 after `VIOL_STEPS` steps with no fault.
- R7: In state 4 `link_ready_o`=1 and both resets are 0. `link_ready_o` is 0 in every other state.
- R8: In states 2, 3 and 4, loss-of-signal or a low PLL lock sends the block to state 0. In states 3 and 4, a code violation, a disparity error or a low CDR lock does the same. Each input passes through a two-flop synchronizer, so the return to state 0 is visible three clock edges after the input changes.
- R9: `pcs_rst_o` is never low while `cdr_rst_o` is high. States advance only 0→1→2→3→4. The only other transitions are from 2 back to 1, and from any state back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| pll_lock_i | input | 1 | Transmit PLL lock status (asynchronous) |
| rx_los_i | input | 1 | Receive loss-of-signal (asynchronous) |
| cdr_lock_i | input | 1 | Receive CDR lock status (asynchronous) |
| code_viol_i | input | 1 | PCS code-violation flag (asynchronous) |
| disp_err_i | input | 1 | PCS disparity-error flag (asynchronous) |
| cdr_rst_o | output | 1 | CDR / receive analog reset, active high, registered |
| pcs_rst_o | output | 1 | Receive PCS reset, active high, registered |
| link_ready_o | output | 1 | Link declared stable, registered |
| state_o | output | 3 | Current sequencer state code |

## Verification
The bound checker holds several properties on every cycle. It checks the reset cascade, which never leaves the PCS released under an active CDR reset. It checks that both resets are asserted in the two early states, that the ready flag is never high while a reset is asserted, and that states change only along the legal paths. It also checks that a loss-of-signal, a PLL unlock or a PCS error seen at the ports two cycles earlier forces the settle state in the states where that input counts as a fault. Only the bench's scenarios can show the lengths of the timed periods and the restart of a period after a brief lock drop. The same holds for the CDR timeout retry, for error flags being ignored while the PCS is held in reset, and for a reset in mid-run.

// File: rtl/rxrst_pkg.sv
package rxrst_pkg;

  typedef enum logic [2:0] {
    SEQ_POWERUP  = 3'd0,
    SEQ_WAIT_PLL = 3'd1,
    SEQ_WAIT_CDR = 3'd2,
    SEQ_WAIT_PCS = 3'd3,
    SEQ_LINK_UP  = 3'd4
  } seq_state_e;

  localparam int STATE_W = 3;

  // Bits needed to hold a step count of max_val.
  function automatic int count_width(input int max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rxrst_sync.sv
module rxrst_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  // One independent flop chain per status bit.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end

    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/rxrst_step_timer.sv
module rxrst_step_timer #(
  parameter int STEP_CYCLES = 4,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  localparam int              PRE_W    = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_CYCLES - 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] steps_q;

  // Saturates at the limit: once expired, the count holds until cleared.
  assign expired = (steps_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q   <= '0;
      steps_q <= '0;
    end else if (run && !expired) begin
      if (pre_q == PRE_LAST) begin
        pre_q   <= '0;
        steps_q <= steps_q + CNT_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

endmodule

// File: rtl/rxrst_fsm.sv
module rxrst_fsm
  import rxrst_pkg::*;
#(
  parameter int POWERUP_STEPS = 4,
  parameter int PLL_STEPS     = 8,
  parameter int CDR_STEPS     = 8,
  parameter int VIOL_STEPS    = 16,
  parameter int CNT_W         = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pll_ok,
  input  logic             los,
  input  logic             cdr_ok,
  input  logic             viol,
  input  logic             disp,
  input  logic             hold_done,
  input  logic             guard_done,
  output logic             hold_clear,
  output logic             hold_run,
  output logic [CNT_W-1:0] hold_limit,
  output logic             guard_clear,
  output logic             guard_run,
  output seq_state_e       state_o,
  output logic             cdr_rst_o,
  output logic             pcs_rst_o,
  output logic             ready_o
);

  localparam logic [CNT_W-1:0] LIM_PWR  = CNT_W'(POWERUP_STEPS);
  localparam logic [CNT_W-1:0] LIM_PLL  = CNT_W'(PLL_STEPS);
  localparam logic [CNT_W-1:0] LIM_CDR  = CNT_W'(CDR_STEPS);
  localparam logic [CNT_W-1:0] LIM_VIOL = CNT_W'(VIOL_STEPS);

  seq_state_e state_q, nxt;
  logic       hold_drop;
  logic       link_fault;
  logic       pcs_fault;

  assign link_fault = !pll_ok || los;
  assign pcs_fault  = link_fault || !cdr_ok || viol || disp;

  always_comb begin
    nxt        = state_q;
    hold_run   = 1'b0;
    hold_drop  = 1'b0;
    hold_limit = '0;
    unique case (state_q)
      SEQ_POWERUP: begin
        hold_run   = 1'b1;
        hold_limit = LIM_PWR;
        if (hold_done) nxt = SEQ_WAIT_PLL;
      end
      SEQ_WAIT_PLL: begin
        hold_limit = LIM_PLL;
        hold_run   = !link_fault;
        hold_drop  = link_fault;
        if (hold_done && !link_fault) nxt = SEQ_WAIT_CDR;
      end
      SEQ_WAIT_CDR: begin
        hold_limit = LIM_CDR;
        if (link_fault) begin
          nxt = SEQ_POWERUP;
        end else begin
          hold_run  = cdr_ok;
          hold_drop = !cdr_ok;
          if (hold_done && cdr_ok) nxt = SEQ_WAIT_PCS;
          else if (guard_done)     nxt = SEQ_WAIT_PLL;
        end
      end
      SEQ_WAIT_PCS: begin
        hold_limit = LIM_VIOL;
        if (pcs_fault) begin
          nxt = SEQ_POWERUP;
        end else begin
          hold_run = 1'b1;
          if (hold_done) nxt = SEQ_LINK_UP;
        end
      end
      SEQ_LINK_UP: begin
        if (pcs_fault) nxt = SEQ_POWERUP;
      end
      default: nxt = SEQ_POWERUP;
    endcase
  end

  // Timers restart on every state change; the hold timer also restarts on a lock drop.
  assign hold_clear  = (nxt != state_q) || hold_drop;
  assign guard_clear = (nxt != state_q);
  assign guard_run   = (state_q == SEQ_WAIT_CDR);

  // Outputs are registered from the next state so they change with the state.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_POWERUP;
      cdr_rst_o <= 1'b1;
      pcs_rst_o <= 1'b1;
      ready_o   <= 1'b0;
    end else begin
      state_q   <= nxt;
      cdr_rst_o <= (nxt == SEQ_POWERUP) || (nxt == SEQ_WAIT_PLL);
      pcs_rst_o <= !((nxt == SEQ_WAIT_PCS) || (nxt == SEQ_LINK_UP));
      ready_o   <= (nxt == SEQ_LINK_UP);
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/rx_reset_sequencer.sv
module rx_reset_sequencer
  import rxrst_pkg::*;
#(
  parameter int STEP_CYCLES     = 4,
  parameter int SYNC_STAGES     = 2,
  parameter int POWERUP_STEPS   = 4,
  parameter int PLL_STEPS       = 8,
  parameter int CDR_STEPS       = 8,
  parameter int CDR_LIMIT_STEPS = 32,
  parameter int VIOL_STEPS      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pll_lock_i,
  input  logic               rx_los_i,
  input  logic               cdr_lock_i,
  input  logic               code_viol_i,
  input  logic               disp_err_i,
  output logic               cdr_rst_o,
  output logic               pcs_rst_o,
  output logic               link_ready_o,
  output logic [STATE_W-1:0] state_o
);

  localparam int MAX_STEPS = max_of(max_of(POWERUP_STEPS, PLL_STEPS),
                                    max_of(max_of(CDR_STEPS, CDR_LIMIT_STEPS), VIOL_STEPS));
  localparam int CNT_W     = count_width(MAX_STEPS);
  localparam int N_STATUS  = 5;

  logic [N_STATUS-1:0] status_raw, status_s;
  logic                hold_clear, hold_run, hold_done;
  logic                guard_clear, guard_run, guard_done;
  logic [CNT_W-1:0]    hold_limit;
  seq_state_e          state;

  assign status_raw = {disp_err_i, code_viol_i, cdr_lock_i, rx_los_i, pll_lock_i};

  rxrst_sync #(
    .WIDTH  (N_STATUS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (status_raw),
    .q_o (status_s)
  );

  // Measures continuous-condition periods (settle, locks, PCS window).
  rxrst_step_timer #(
    .STEP_CYCLES (STEP_CYCLES),
    .CNT_W       (CNT_W)
  ) u_hold_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (hold_clear),
    .run     (hold_run),
    .limit   (hold_limit),
    .expired (hold_done)
  );

  // Bounds the total time spent waiting for the CDR.
  rxrst_step_timer #(
    .STEP_CYCLES (STEP_CYCLES),
    .CNT_W       (CNT_W)
  ) u_guard_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (guard_clear),
    .run     (guard_run),
    .limit   (CNT_W'(CDR_LIMIT_STEPS)),
    .expired (guard_done)
  );

  rxrst_fsm #(
    .POWERUP_STEPS (POWERUP_STEPS),
    .PLL_STEPS     (PLL_STEPS),
    .CDR_STEPS     (CDR_STEPS),
    .VIOL_STEPS    (VIOL_STEPS),
    .CNT_W         (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pll_ok      (status_s[0]),
    .los         (status_s[1]),
    .cdr_ok      (status_s[2]),
    .viol        (status_s[3]),
    .disp        (status_s[4]),
    .hold_done   (hold_done),
    .guard_done  (guard_done),
    .hold_clear  (hold_clear),
    .hold_run    (hold_run),
    .hold_limit  (hold_limit),
    .guard_clear (guard_clear),
    .guard_run   (guard_run),
    .state_o     (state),
    .cdr_rst_o   (cdr_rst_o),
    .pcs_rst_o   (pcs_rst_o),
    .ready_o     (link_ready_o)
  );

  assign state_o = state;

endmodule

// File: rtl/rxrst_checker.sv
module rxrst_checker (
  input logic       clk,
  input logic       rst,
  input logic       pll_lock_i,
  input logic       rx_los_i,
  input logic       cdr_lock_i,
  input logic       code_viol_i,
  input logic       disp_err_i,
  input logic       cdr_rst_o,
  input logic       pcs_rst_o,
  input logic       link_ready_o,
  input logic [2:0] state_o
);

  // R9: the PCS is never out of reset while the CDR is held.
  assert_cascade_R9: assert property (@(posedge clk) disable iff (rst)
    cdr_rst_o |-> pcs_rst_o);

  // R2: settle and PLL-wait states hold both resets.
  assert_early_resets_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 || state_o == 3'd1) |-> (cdr_rst_o && pcs_rst_o));

  // R7: ready only with every reset released.
  assert_ready_released_R7: assert property (@(posedge clk) disable iff (rst)
    link_ready_o |-> (!cdr_rst_o && !pcs_rst_o));

  // R9: legal transitions only.
  assert_order_R9: assert property (@(posedge clk) disable iff (rst)
    (state_o != $past(state_o) && state_o != 3'd0) |->
      (state_o == $past(state_o) + 3'd1 ||
       (state_o == 3'd1 && $past(state_o) == 3'd2)));

  // R8: loss-of-signal after CDR release restarts the sequence.
  assert_los_restart_R8: assert property (@(posedge clk) disable iff (rst)
    ((state_o == 3'd2 || state_o == 3'd3 || state_o == 3'd4) && $past(rx_los_i, 2))
      |=> (state_o == 3'd0));

  // R8: PLL unlock after CDR release restarts the sequence.
  assert_pll_restart_R8: assert property (@(posedge clk) disable iff (rst)
    ((state_o == 3'd2 || state_o == 3'd3 || state_o == 3'd4) && !$past(pll_lock_i, 2))
      |=> (state_o == 3'd0));

  // R8: PCS errors or CDR unlock once the PCS runs restart the sequence.
  assert_pcs_restart_R8: assert property (@(posedge clk) disable iff (rst)
    ((state_o == 3'd3 || state_o == 3'd4) &&
     ($past(code_viol_i, 2) || $past(disp_err_i, 2) || !$past(cdr_lock_i, 2)))
      |=> (state_o == 3'd0));

endmodule

bind rx_reset_sequencer rxrst_checker u_checker (
  .clk          (clk),
  .rst          (rst),
  .pll_lock_i   (pll_lock_i),
  .rx_los_i     (rx_los_i),
  .cdr_lock_i   (cdr_lock_i),
  .code_viol_i  (code_viol_i),
  .disp_err_i   (disp_err_i),
  .cdr_rst_o    (cdr_rst_o),
  .pcs_rst_o    (pcs_rst_o),
  .link_ready_o (link_ready_o),
  .state_o      (state_o)
);

// File: tb/rx_reset_sequencer_test.sv
module rx_reset_sequencer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pll_lock_i = 1'b0, rx_los_i = 1'b0, cdr_lock_i = 1'b0;
  logic       code_viol_i = 1'b0, disp_err_i = 1'b0;
  logic       cdr_rst_o, pcs_rst_o, link_ready_o;
  logic [2:0] state_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rx_reset_sequencer #(
    .STEP_CYCLES     (4),
    .SYNC_STAGES     (2),
    .POWERUP_STEPS   (4),
    .PLL_STEPS       (8),
    .CDR_STEPS       (8),
    .CDR_LIMIT_STEPS (32),
    .VIOL_STEPS      (16)
  ) uut (
    .clk          (clk),
    .rst          (rst),
    .pll_lock_i   (pll_lock_i),
    .rx_los_i     (rx_los_i),
    .cdr_lock_i   (cdr_lock_i),
    .code_viol_i  (code_viol_i),
    .disp_err_i   (disp_err_i),
    .cdr_rst_o    (cdr_rst_o),
    .pcs_rst_o    (pcs_rst_o),
    .link_ready_o (link_ready_o),
    .state_o      (state_o)
  );

  typedef struct packed {
    logic       pll;
    logic       los;
    logic       cdr;
    logic       viol;
    logic       disp;
    logic [8:0] cycles;
    logic [2:0] st;
    logic [3:0] req;
  } vec_t;

  // Timing with step = 4 clocks: settle ~17, PLL ~35, CDR ~35, PCS window ~65 cycles.
  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 9'd8,   3'd0, 4'd2}, // R2 still settling
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 9'd30,  3'd1, 4'd2}, // R2 settle done, no PLL
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 9'd20,  3'd1, 4'd3}, // R3 lock not yet held long enough
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 9'd20,  3'd2, 4'd3}, // R3 PLL period met
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 9'd40,  3'd3, 4'd4}, // R4 CDR lock held
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 9'd30,  3'd3, 4'd6}, // R6 window still open
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 9'd40,  3'd4, 4'd7}, // R7 link up
    '{1'b1,1'b0,1'b1,1'b1,1'b0, 9'd4,   3'd0, 4'd8}, // R8 code violation
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 9'd10,  3'd0, 4'd2}, // R2 settling again
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 9'd60,  3'd2, 4'd4}, // R4 CDR stage reached
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 9'd100, 3'd4, 4'd6}, // R6 clean window passed
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 9'd4,   3'd0, 4'd8}, // R8 loss of signal
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 9'd60,  3'd1, 4'd3}, // R3 waits for PLL
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 9'd200, 3'd4, 4'd7}, // R7 full bring-up
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 9'd4,   3'd0, 4'd8}, // R8 PLL unlock
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 9'd200, 3'd4, 4'd6}, // R6 bring-up again
    '{1'b1,1'b0,1'b1,1'b0,1'b1, 9'd4,   3'd0, 4'd8}, // R8 disparity error
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 9'd4,   3'd0, 4'd2}  // R2 held in settle
  };

  task automatic run_cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Expected outputs follow from the state code (R2, R4, R6, R7, R9).
  task automatic check_state(input logic [2:0] exp_st, input string tag);
    logic exp_cdr, exp_pcs, exp_rdy;
    exp_cdr = (exp_st == 3'd0) || (exp_st == 3'd1);
    exp_pcs = (exp_st <= 3'd2);
    exp_rdy = (exp_st == 3'd4);
    checks++;
    if (state_o !== exp_st || cdr_rst_o !== exp_cdr ||
        pcs_rst_o !== exp_pcs || link_ready_o !== exp_rdy) begin
      errors++;
      $display("FAIL %s: state=%0d cdr_rst=%b pcs_rst=%b ready=%b expected state=%0d cdr_rst=%b pcs_rst=%b ready=%b",
               tag, state_o, cdr_rst_o, pcs_rst_o, link_ready_o,
               exp_st, exp_cdr, exp_pcs, exp_rdy);
    end
  endtask

  task automatic wait_state(input logic [2:0] s, input string tag);
    int n = 0;
    while (state_o !== s && n < 600) begin
      run_cycles(1);
      n++;
    end
    check_state(s, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    run_cycles(3);
    check_state(3'd0, "R1 reset state");
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      pll_lock_i  = VECS[i].pll;
      rx_los_i    = VECS[i].los;
      cdr_lock_i  = VECS[i].cdr;
      code_viol_i = VECS[i].viol;
      disp_err_i  = VECS[i].disp;
      run_cycles(int'(VECS[i].cycles));
      check_state(VECS[i].st, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R4: errors ignored while the PCS is held; R9 cascade in the CDR stage.
    cdr_lock_i = 1'b0;
    wait_state(3'd2, "R4 enter CDR wait");
    code_viol_i = 1'b1;
    disp_err_i  = 1'b1;
    run_cycles(10);
    check_state(3'd2, "R4 errors ignored in CDR wait");
    check_state(3'd2, "R9 PCS held while CDR released");
    code_viol_i = 1'b0;
    disp_err_i  = 1'b0;

    // R5: CDR timeout after 32 steps (~129 cycles from entry).
    run_cycles(90);
    check_state(3'd2, "R5 before CDR timeout");
    run_cycles(45);
    check_state(3'd1, "R5 retry from PLL wait");

    // R3: a brief PLL drop restarts the lock period.
    pll_lock_i = 1'b0;
    run_cycles(5);
    pll_lock_i = 1'b1;
    run_cycles(20);
    pll_lock_i = 1'b0;
    run_cycles(3);
    pll_lock_i = 1'b1;
    run_cycles(25);
    check_state(3'd1, "R3 lock period restarted");
    run_cycles(15);
    check_state(3'd2, "R3 lock period met after restart");

    // R1: synchronous reset in mid-run.
    cdr_lock_i = 1'b1;
    wait_state(3'd4, "R7 link up before reset");
    rst = 1'b1;
    run_cycles(1);
    check_state(3'd0, "R1 reset from link up");
    rst = 1'b0;

    // R8: CDR unlock while the link is up, seen three edges later.
    wait_state(3'd4, "R7 link up again");
    cdr_lock_i = 1'b0;
    run_cycles(2);
    check_state(3'd4, "R8 fault not yet through synchronizer");
    run_cycles(1);
    check_state(3'd0, "R8 CDR unlock restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule